// File: doc/BRIEF.md
# Three-Entry CAN Receive Queue

This block holds accepted CAN messages between the protocol core and software. When the core sees a message that passed filtering, it raises a one-cycle store strobe together with the message fields: the identifier, the extended-format and remote-request bits, the length code, eight data bytes, the index of the filter that matched, and the arrival timestamp. The queue keeps up to three such messages and handles them entirely in hardware. The oldest message is always visible on the output mailbox port. Software reads it from there and then pulses a release strobe to bring the next message forward.

Occupancy is shown as a 2-bit pending count. A sticky full flag and a sticky overrun flag are also provided, and software clears each one with its own one-cycle clear strobe. When a fourth message arrives and nothing is released in the same cycle, one message is lost. A lock-mode input chooses which one: with lock mode off, the newest stored message is replaced; with lock mode on, the arriving message is dropped. Three interrupt requests report pending data, full and overrun, and each is gated by its own enable input.

All state is registered. The count, the flags and the output mailbox change on the clock edge at which a strobe is sampled. The interrupt outputs follow the registered state, gated combinationally by their enables. The reset is asynchronous and active low, and it must be released synchronously to the clock.

Top module: `can_rx_fifo3`

## Requirements
- R1: While reset is asserted and after it is released, the pending count is 00, both status flags are 0 and all three interrupt requests are 0.
- R2: A store strobe with fewer than three messages held raises the pending count by one at the next clock edge. The encoding is 00 for empty, 01 for one message, 10 for two and 11 for three.
- R3: The output mailbox shows every field of the oldest held message, and messages leave in the order in which they were stored.
- R4: A release strobe while messages are held lowers the pending count by one and presents the next message. A release strobe while the queue is empty leaves the count at 00.
- R5: A store and a release in the same cycle leave the pending count unchanged and present the next message, even when three messages are held.
- R6: A store strobe with three messages held and no release in the same cycle sets the overrun flag and leaves the count at 11.
- R7: With lock mode 0, an overrun replaces the most recently stored message with the arriving one. The two older messages are kept.
- R8: With lock mode 1, an overrun discards the arriving message and keeps the three held ones unchanged.
- R9: The full flag sets when a store brings the count from 10 to 11. It clears on the full-clear strobe or on a release while messages are held. A set in the same cycle takes priority over a clear.
- R10: The overrun flag stays set until the overrun-clear strobe. An overrun in the same cycle as that strobe keeps the flag set.
- R11: irq_pend equals ie_pend AND (count not 00), irq_full equals ie_full AND the full flag, and irq_ovr equals ie_ovr AND the overrun flag.
- R12: While the queue is empty, every output mailbox field reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe: store an accepted message |
| wr_id | input | 29 | Identifier (standard ID in bits 28:18 when wr_ide is 0) |
| wr_ide | input | 1 | Extended-identifier flag |
| wr_rtr | input | 1 | Remote-request flag |
| wr_dlc | input | 4 | Data length code |
| wr_data | input | 64 | Data bytes |
| wr_fmi | input | 8 | Matching filter index |
| wr_ts | input | 16 | Arrival timestamp |
| lock_mode | input | 1 | 1: drop the arriving message on overrun; 0: replace the newest |
| rd_release | input | 1 | One-cycle strobe: free the oldest message |
| full_clr | input | 1 | One-cycle strobe: clear the full flag |
| ovr_clr | input | 1 | One-cycle strobe: clear the overrun flag |
| ie_pend | input | 1 | Enable for the pending interrupt |
| ie_full | input | 1 | Enable for the full interrupt |
| ie_ovr | input | 1 | Enable for the overrun interrupt |
| out_id | output | 29 | Oldest message identifier |
| out_ide | output | 1 | Oldest message extended flag |
| out_rtr | output | 1 | Oldest message remote flag |
| out_dlc | output | 4 | Oldest message length code |
| out_data | output | 64 | Oldest message data |
| out_fmi | output | 8 | Oldest message filter index |
| out_ts | output | 16 | Oldest message timestamp |
| pend_cnt | output | 2 | Number of messages held |
| full_flag | output | 1 | Sticky full status |
| ovr_flag | output | 1 | Sticky overrun status |
| irq_pend | output | 1 | Pending interrupt request |
| irq_full | output | 1 | Full interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The assertions check, on every cycle, how the pending count responds to each mix of store and release, the setting of both flags, the interrupt gating, the zeroed mailbox when the queue is empty, and that the oldest identifier stays put during an overrun. Three behaviours only the bench scenarios can show. The first is which message survives an overrun in each lock mode, which becomes visible only after later releases. The second is that every field stays in order through a fill and drain. The third is the flag behaviour when a set and a clear meet in the same cycle.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  parameter int ID_W   = 29;
  parameter int DLC_W  = 4;
  parameter int DATA_W = 64;
  parameter int FMI_W  = 8;
  parameter int TS_W   = 16;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
    logic [FMI_W-1:0]  fmi;
    logic [TS_W-1:0]   ts;
  } rx_msg_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rd_release,
  input  logic             lock_mode,
  output logic [CW-1:0]    cnt,
  output logic [PW-1:0]    rd_ptr,
  output logic [DEPTH-1:0] wr_sel,
  output logic             store_last,
  output logic             overrun,
  output logic             rel_ok
);
  logic [PW-1:0] wr_ptr, wr_ptr_n, rd_ptr_n, newest;
  logic [CW-1:0] cnt_n;
  logic          at_full, accept, overwrite, ptr_en;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    at_full    = (cnt == CW'(DEPTH));
    rel_ok     = rd_release && (cnt != '0);
    accept     = wr_valid && (!at_full || rel_ok);
    overrun    = wr_valid && at_full && !rel_ok;
    overwrite  = overrun && !lock_mode;
    newest     = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
    store_last = accept && !rel_ok && (cnt == CW'(DEPTH - 1));
    wr_ptr_n   = accept ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_n   = rel_ok ? ptr_inc(rd_ptr) : rd_ptr;
    cnt_n      = cnt + CW'(accept) - CW'(rel_ok);
    ptr_en     = accept || rel_ok;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign wr_sel[i] = (accept && (wr_ptr == PW'(i))) ||
                       (overwrite && (newest == PW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (ptr_en) begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  rx_msg_t          wr_msg,
  input  logic [DEPTH-1:0] wr_sel,
  input  logic [PW-1:0]    rd_ptr,
  input  logic             not_empty,
  output rx_msg_t          rd_msg
);
  rx_msg_t slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_sel[i]) slot[i] <= wr_msg;
    end
  end

  always_comb begin
    rd_msg = '0;
    if (not_empty) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rd_ptr == PW'(i)) rd_msg = slot[i];
      end
    end
  end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic store_last,
  input  logic overrun,
  input  logic rel_ok,
  input  logic full_clr,
  input  logic ovr_clr,
  input  logic not_empty,
  input  logic ie_pend,
  input  logic ie_full,
  input  logic ie_ovr,
  output logic full_flag,
  output logic ovr_flag,
  output logic irq_pend,
  output logic irq_full,
  output logic irq_ovr
);
  logic full_n, ovr_n, full_en, ovr_en;

  always_comb begin
    full_en = store_last || full_clr || rel_ok;
    full_n  = store_last;
    ovr_en  = overrun || ovr_clr;
    ovr_n   = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      if (full_en) full_flag <= full_n;
      if (ovr_en)  ovr_flag  <= ovr_n;
    end
  end

  assign irq_pend = ie_pend && not_empty;
  assign irq_full = ie_full && full_flag;
  assign irq_ovr  = ie_ovr && ovr_flag;
endmodule

// File: rtl/can_rx_fifo3.sv
module can_rx_fifo3
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              wr_ide,
  input  logic              wr_rtr,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FMI_W-1:0]  wr_fmi,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic              lock_mode,
  input  logic              rd_release,
  input  logic              full_clr,
  input  logic              ovr_clr,
  input  logic              ie_pend,
  input  logic              ie_full,
  input  logic              ie_ovr,
  output logic [ID_W-1:0]   out_id,
  output logic              out_ide,
  output logic              out_rtr,
  output logic [DLC_W-1:0]  out_dlc,
  output logic [DATA_W-1:0] out_data,
  output logic [FMI_W-1:0]  out_fmi,
  output logic [TS_W-1:0]   out_ts,
  output logic [CW-1:0]     pend_cnt,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq_pend,
  output logic              irq_full,
  output logic              irq_ovr
);
  rx_msg_t          in_msg, head_msg;
  logic [PW-1:0]    rd_ptr;
  logic [DEPTH-1:0] wr_sel;
  logic             store_last, overrun, rel_ok, not_empty;

  assign in_msg    = '{id: wr_id, ide: wr_ide, rtr: wr_rtr, dlc: wr_dlc,
                       data: wr_data, fmi: wr_fmi, ts: wr_ts};
  assign not_empty = (pend_cnt != '0);

  rxf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .rd_release (rd_release),
    .lock_mode  (lock_mode),
    .cnt        (pend_cnt),
    .rd_ptr     (rd_ptr),
    .wr_sel     (wr_sel),
    .store_last (store_last),
    .overrun    (overrun),
    .rel_ok     (rel_ok)
  );

  rxf_store #(.DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .wr_msg    (in_msg),
    .wr_sel    (wr_sel),
    .rd_ptr    (rd_ptr),
    .not_empty (not_empty),
    .rd_msg    (head_msg)
  );

  rxf_flags flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_last (store_last),
    .overrun    (overrun),
    .rel_ok     (rel_ok),
    .full_clr   (full_clr),
    .ovr_clr    (ovr_clr),
    .not_empty  (not_empty),
    .ie_pend    (ie_pend),
    .ie_full    (ie_full),
    .ie_ovr     (ie_ovr),
    .full_flag  (full_flag),
    .ovr_flag   (ovr_flag),
    .irq_pend   (irq_pend),
    .irq_full   (irq_full),
    .irq_ovr    (irq_ovr)
  );

  assign out_id   = head_msg.id;
  assign out_ide  = head_msg.ide;
  assign out_rtr  = head_msg.rtr;
  assign out_dlc  = head_msg.dlc;
  assign out_data = head_msg.data;
  assign out_fmi  = head_msg.fmi;
  assign out_ts   = head_msg.ts;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            rd_release,
  input logic            lock_mode,
  input logic            ovr_clr,
  input logic            ie_pend,
  input logic            ie_full,
  input logic            ie_ovr,
  input logic [ID_W-1:0] out_id,
  input logic [DLC_W-1:0] out_dlc,
  input logic [CW-1:0]   pend_cnt,
  input logic            full_flag,
  input logic            ovr_flag,
  input logic            irq_pend,
  input logic            irq_full,
  input logic            irq_ovr
);
  logic at_top;
  assign at_top = (pend_cnt == CW'(DEPTH));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pend_cnt == '0) && !full_flag && !ovr_flag);

  a_r2_store_inc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_release && !at_top |=> pend_cnt == $past(pend_cnt) + 1'b1);

  a_r4_release_dec: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release && !wr_valid && (pend_cnt != '0) |=> pend_cnt == $past(pend_cnt) - 1'b1);

  a_r4_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release && !wr_valid && (pend_cnt == '0) |=> pend_cnt == '0);

  a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rd_release && (pend_cnt != '0) |=> $stable(pend_cnt));

  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_release && at_top |=> ovr_flag && (pend_cnt == CW'(DEPTH)));

  a_r3_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_release && at_top |=> $stable(out_id));

  a_r9_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_release && (pend_cnt == CW'(DEPTH - 1)) |=> full_flag);

  a_r10_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(wr_valid && !rd_release && at_top) |=> !ovr_flag);

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend == (ie_pend && (pend_cnt != '0))) &&
    (irq_full == (ie_full && full_flag)) &&
    (irq_ovr == (ie_ovr && ovr_flag)));

  a_r12_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0) |-> (out_id == '0) && (out_dlc == '0));
endmodule

bind can_rx_fifo3 rxf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .rd_release (rd_release),
  .lock_mode  (lock_mode),
  .ovr_clr    (ovr_clr),
  .ie_pend    (ie_pend),
  .ie_full    (ie_full),
  .ie_ovr     (ie_ovr),
  .out_id     (out_id),
  .out_dlc    (out_dlc),
  .pend_cnt   (pend_cnt),
  .full_flag  (full_flag),
  .ovr_flag   (ovr_flag),
  .irq_pend   (irq_pend),
  .irq_full   (irq_full),
  .irq_ovr    (irq_ovr)
);

// File: tb/can_rx_fifo3_tb_top.sv
module can_rx_fifo3_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [28:0] wr_id = '0;
  logic        wr_ide = 1'b0, wr_rtr = 1'b0;
  logic [3:0]  wr_dlc = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_fmi = '0;
  logic [15:0] wr_ts = '0;
  logic        lock_mode = 1'b0, rd_release = 1'b0, full_clr = 1'b0, ovr_clr = 1'b0;
  logic        ie_pend = 1'b0, ie_full = 1'b0, ie_ovr = 1'b0;
  logic [28:0] out_id;
  logic        out_ide, out_rtr;
  logic [3:0]  out_dlc;
  logic [63:0] out_data;
  logic [7:0]  out_fmi;
  logic [15:0] out_ts;
  logic [1:0]  pend_cnt;
  logic        full_flag, ovr_flag, irq_pend, irq_full, irq_ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_rx_fifo3 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id),
    .wr_ide(wr_ide), .wr_rtr(wr_rtr), .wr_dlc(wr_dlc), .wr_data(wr_data),
    .wr_fmi(wr_fmi), .wr_ts(wr_ts), .lock_mode(lock_mode),
    .rd_release(rd_release), .full_clr(full_clr), .ovr_clr(ovr_clr),
    .ie_pend(ie_pend), .ie_full(ie_full), .ie_ovr(ie_ovr),
    .out_id(out_id), .out_ide(out_ide), .out_rtr(out_rtr), .out_dlc(out_dlc),
    .out_data(out_data), .out_fmi(out_fmi), .out_ts(out_ts),
    .pend_cnt(pend_cnt), .full_flag(full_flag), .ovr_flag(ovr_flag),
    .irq_pend(irq_pend), .irq_full(irq_full), .irq_ovr(irq_ovr)
  );

  function automatic logic [63:0] data_of(input logic [28:0] id);
    return {3'b101, id, ~id[15:0], id[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive message fields derived from id (inputs change #1 after posedge)
  task automatic set_msg(input logic [28:0] id);
    wr_id   = id;
    wr_ide  = id[0];
    wr_rtr  = id[1];
    wr_dlc  = id[5:2];
    wr_data = data_of(id);
    wr_fmi  = id[7:0] ^ 8'h3C;
    wr_ts   = id[15:0] ^ 16'h5A5A;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rd_release = 1'b0; full_clr = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic push(input logic [28:0] id);
    set_msg(id);
    wr_valid = 1'b1;
    tick();
  endtask

  task automatic release_one();
    rd_release = 1'b1;
    tick();
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) release_one();
    ovr_clr = 1'b1; full_clr = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 count", 64'(pend_cnt), 0);
    chk("R1 flags", {62'd0, full_flag, ovr_flag}, 0);
    chk("R1 irqs", {61'd0, irq_pend, irq_full, irq_ovr}, 0);
    chk("R12 empty id", 64'(out_id), 0);
    chk("R12 empty data", out_data, 0);
  endtask

  task automatic t_fill_order();
    push(29'h0100_0001);
    chk("R2 count one", 64'(pend_cnt), 1);
    push(29'h0200_0042);
    chk("R2 count two", 64'(pend_cnt), 2);
    chk("R9 full not yet", 64'(full_flag), 0);
    push(29'h0300_0083);
    chk("R2 count three", 64'(pend_cnt), 3);
    chk("R9 full set", 64'(full_flag), 1);
    chk("R3 head id", 64'(out_id), 64'(29'h0100_0001));
    chk("R3 head data", out_data, data_of(29'h0100_0001));
    chk("R3 head ts", 64'(out_ts), 64'(16'h0001 ^ 16'h5A5A));
    chk("R3 head fmi", 64'(out_fmi), 64'(8'h01 ^ 8'h3C));
    chk("R3 head dlc/ide/rtr", {58'd0, out_dlc, out_rtr, out_ide}, 64'({4'h0, 1'b0, 1'b1}));
    release_one();
    chk("R4 dec", 64'(pend_cnt), 2);
    chk("R9 release clears full", 64'(full_flag), 0);
    chk("R3 second", 64'(out_id), 64'(29'h0200_0042));
    release_one();
    chk("R3 third", 64'(out_id), 64'(29'h0300_0083));
    release_one();
    chk("R4 empty", 64'(pend_cnt), 0);
    chk("R12 zero after drain", 64'(out_ts), 0);
    release_one();
    chk("R4 release on empty", 64'(pend_cnt), 0);
    push(29'h0000_0AAA);
    chk("R4 release on empty no effect", 64'(out_id), 64'(29'h0000_0AAA));
    drain();
  endtask

  task automatic t_simul();
    push(29'h0011_1111);
    set_msg(29'h0022_2222);
    wr_valid = 1'b1; rd_release = 1'b1;
    tick();
    chk("R5 count held", 64'(pend_cnt), 1);
    chk("R5 next shown", 64'(out_id), 64'(29'h0022_2222));
    push(29'h0033_3333);
    push(29'h0044_4444);
    set_msg(29'h0055_5555);
    wr_valid = 1'b1; rd_release = 1'b1;
    tick();
    chk("R5 full swap count", 64'(pend_cnt), 3);
    chk("R5 full swap no overrun", 64'(ovr_flag), 0);
    chk("R5 full swap head", 64'(out_id), 64'(29'h0033_3333));
    release_one(); release_one();
    chk("R5 stored at tail", 64'(out_id), 64'(29'h0055_5555));
    drain();
  endtask

  task automatic t_overwrite();
    lock_mode = 1'b0; ie_ovr = 1'b1;
    push(29'h0A); push(29'h0B); push(29'h0C);
    chk("R11 irq_ovr before", 64'(irq_ovr), 0);
    push(29'h0D);
    chk("R6 ovr set", 64'(ovr_flag), 1);
    chk("R6 count stays", 64'(pend_cnt), 3);
    chk("R11 irq_ovr", 64'(irq_ovr), 1);
    release_one();
    chk("R7 second kept", 64'(out_id), 64'(29'h0B));
    release_one();
    chk("R7 newest replaced", 64'(out_id), 64'(29'h0D));
    chk("R7 replaced data", out_data, data_of(29'h0D));
    chk("R10 ovr sticky", 64'(ovr_flag), 1);
    ovr_clr = 1'b1;
    tick();
    chk("R10 ovr cleared", 64'(ovr_flag), 0);
    ie_ovr = 1'b0;
    drain();
  endtask

  task automatic t_lock();
    lock_mode = 1'b1;
    push(29'h1A); push(29'h1B); push(29'h1C); push(29'h1D);
    chk("R8 ovr set", 64'(ovr_flag), 1);
    release_one();
    chk("R8 second", 64'(out_id), 64'(29'h1B));
    release_one();
    chk("R8 third kept", 64'(out_id), 64'(29'h1C));
    release_one();
    chk("R8 incoming dropped", 64'(pend_cnt), 0);
    lock_mode = 1'b0;
    drain();
  endtask

  task automatic t_flag_prio();
    push(29'h21); push(29'h22);
    set_msg(29'h23);
    wr_valid = 1'b1; full_clr = 1'b1;
    tick();
    chk("R9 set beats clear", 64'(full_flag), 1);
    full_clr = 1'b1;
    tick();
    chk("R9 clear strobe", 64'(full_flag), 0);
    chk("R9 clear keeps count", 64'(pend_cnt), 3);
    set_msg(29'h24);
    wr_valid = 1'b1; ovr_clr = 1'b1;
    tick();
    chk("R10 set beats clear", 64'(ovr_flag), 1);
    drain();
  endtask

  task automatic t_irq();
    push(29'h31); push(29'h32); push(29'h33); push(29'h34);
    chk("R11 gated off", {61'd0, irq_pend, irq_full, irq_ovr}, 0);
    ie_pend = 1'b1; ie_full = 1'b1; ie_ovr = 1'b1;
    #1;
    chk("R11 gated on", {61'd0, irq_pend, irq_full, irq_ovr}, 64'h7);
    drain();
    chk("R11 pend drops when empty", 64'(irq_pend), 0);
    ie_pend = 1'b0; ie_full = 1'b0; ie_ovr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill_order();
    t_simul();
    t_overwrite();
    t_lock();
    t_flag_prio();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule